// File: doc/BRIEF.md
# Serial Configuration Stream Checker

This block takes a configuration bitstream one bit per clock, with a strobe that marks the cycles carrying a bit. It scans for a header marker. It then captures a 24-bit length word and verifies a short run of pad ones. After that it walks the body as a fixed number of equal-sized frames. Each frame opens with a zero marker bit, carries its payload and closes with a check field. A good frame's payload appears on a parallel bus together with a single-cycle strobe.

Two checking schemes are available, chosen when the header marker is found. The constant scheme expects a fixed four-bit code after every frame. The CRC scheme keeps a 16-bit CRC running over the stream and expects its top bits as each frame's trailer. In that scheme the final frame carries a wider trailer. A closing byte ends the stream and raises the completion flag.

Any violation stops the block in a fault state and pulls the active-low error line down. The fault holds until a low pulse arrives on the reprogram input, which restarts the header search.

Top module: `cfg_stream_checker`

## Requirements
- R1: While searching, the block ignores every bit until the last four accepted bits, oldest first, read 0,0,1,0; a stream of leading ones and non-matching bits before that marker does not disturb the following parse.
- R2: The 24 bits after the marker form the length word, most significant bit first, and appear on `lenCount` once the 24th bit is accepted.
- R3: The four bits after the length word must all be 1; a 0 among them sends the block to the fault state.
- R4: Every frame opens with one marker bit that must be 0; a 1 there sends the block to the fault state.
- R5: Each frame's FRAME_BITS payload bits, most significant first, appear on `frameData` with `frameValid` high for exactly one cycle, starting on the edge that accepts the frame's last trailer bit; the strobe only follows a fully matching trailer.
- R6: In constant mode every trailer is 4 bits and must read 0,1,1,0 in order of arrival; any other bit causes a fault.
- R7: In CRC mode a 16-bit CRC (polynomial x^16+x^15+x^2+1, shifted MSB-first, feedback = top bit XOR input) is cleared at the marker and updated with every accepted bit except trailer bits; a trailer must equal the CRC's bits 15, 14, 13, ... in order of arrival.
- R8: In CRC mode the last frame's trailer is 11 bits (CRC bits 15 down to 5); a mismatch in its 11th bit causes a fault.
- R9: The `crcMode` input (1 = CRC, 0 = constant) is sampled only on the edge that accepts the marker; changes later in the stream have no effect.
- R10: After the last frame, the closing byte must read 0 then seven 1s; `done` rises on the edge that accepts its final bit, and it stays low on any fault.
- R11: In the fault state `errN` is 0, input bits are ignored and `frameValid` and `done` stay low, until a reprogram pulse.
- R12: A cycle with `progN` low returns the block from any state to header search, with `errN` high and `done` low afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| progN | input | 1 | Synchronous active-low reprogram pulse |
| bitIn | input | 1 | Serial stream bit |
| bitValid | input | 1 | High in cycles that carry a stream bit |
| crcMode | input | 1 | 1 selects CRC trailers, 0 the constant trailer |
| lenCount | output | 24 | Captured length word |
| frameData | output | FRAME_BITS | Payload of the last good frame |
| frameValid | output | 1 | One-cycle strobe per good frame |
| done | output | 1 | Stream complete without fault |
| errN | output | 1 | Active-low fault indication |

## Verification
Dozens of well-formed streams with varied payloads, length words and idle gaps run in both modes. The mode input is inverted right after each marker, so a design that keeps following it fails at the first trailer. Faulty streams each carry one defect: a zero among the pad ones, a one as a frame marker, a flipped trailer bit in a middle frame, a flipped 11th bit of the final CRC trailer, or a bad closing byte. Each one separates the right fault path from its neighbours, and the bits sent afterwards, including a fresh marker pattern, show that the fault holds. A reprogram pulse in the middle of a frame and after every run shows that the restart works from any state.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;
  localparam int LEN_BITS   = 24;
  localparam int CRC_BITS   = 16;
  localparam int PAD_BITS   = 4;
  localparam int TRAIL_BITS = 4;
  localparam int LAST_TRAIL = 11;
  localparam int CLOSE_BITS = 8;
  localparam logic [3:0] MARKER = 4'b0010;
  localparam logic [TRAIL_BITS-1:0] TRAIL_CONST = 4'b0110;
  localparam logic [CRC_BITS-1:0] CRC_POLY = 16'h8005;

  typedef enum logic [3:0] {
    S_HUNT, S_LEN, S_PAD, S_MARK, S_DATA, S_TRAIL, S_CLOSE, S_DONE, S_FAULT
  } phase_t;

  typedef struct packed {
    logic restart;
    logic shiftWin;
    logic crcEn;
    logic shiftLen;
    logic shiftData;
    logic loadFrame;
  } strobe_t;
endpackage

// File: rtl/cfg_stream_dp.sv
module cfg_stream_dp
  import cfg_stream_pkg::*;
#(
  parameter int FRAME_BITS = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  bitIn,
  input  strobe_t               stb,
  output logic                  markerHit,
  output logic [CRC_BITS-1:0]   crc,
  output logic [LEN_BITS-1:0]   lenCount,
  output logic [FRAME_BITS-1:0] frameData,
  output logic                  frameValid
);
  logic [3:0]            win;
  logic [FRAME_BITS-1:0] dataSh;
  logic [CRC_BITS-1:0]   crcNxt;

  assign markerHit = ({win[2:0], bitIn} == MARKER);
  assign crcNxt = {crc[CRC_BITS-2:0], 1'b0} ^ ((crc[CRC_BITS-1] ^ bitIn) ? CRC_POLY : '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      win        <= '1;
      crc        <= '0;
      lenCount   <= '0;
      dataSh     <= '0;
      frameData  <= '0;
      frameValid <= 1'b0;
    end else begin
      if (stb.restart) begin
        win      <= '1;
        crc      <= '0;
        lenCount <= '0;
      end else begin
        if (stb.shiftWin) win <= {win[2:0], bitIn};
        if (stb.crcEn) crc <= crcNxt;
        if (stb.shiftLen) lenCount <= {lenCount[LEN_BITS-2:0], bitIn};
      end
      if (stb.shiftData) dataSh <= {dataSh[FRAME_BITS-2:0], bitIn};
      if (stb.loadFrame) frameData <= dataSh;
      frameValid <= stb.loadFrame;
    end
  end

  AST_CRC_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    stb.restart |=> (crc == '0)); // R7
  AST_CRC_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.restart && !stb.crcEn) |=> $stable(crc)); // R7
  AST_FRAME_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |=> !frameValid); // R5
endmodule

// File: rtl/cfg_stream_ctl.sv
module cfg_stream_ctl
  import cfg_stream_pkg::*;
#(
  parameter int FRAME_BITS = 8,
  parameter int NUM_FRAMES = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                progN,
  input  logic                bitIn,
  input  logic                bitValid,
  input  logic                crcMode,
  input  logic                markerHit,
  input  logic [CRC_BITS-1:0] crc,
  output strobe_t             stb,
  output logic                done,
  output logic                errN
);
  localparam int MAX_CNT = (LEN_BITS > FRAME_BITS) ? LEN_BITS : FRAME_BITS;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);
  localparam int FRM_W   = $clog2(NUM_FRAMES + 1);
  localparam logic [CNT_W-1:0] LEN_END   = CNT_W'(LEN_BITS - 1);
  localparam logic [CNT_W-1:0] PAD_END   = CNT_W'(PAD_BITS - 1);
  localparam logic [CNT_W-1:0] DATA_END  = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] TRAIL_END = CNT_W'(TRAIL_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_END  = CNT_W'(LAST_TRAIL - 1);
  localparam logic [CNT_W-1:0] CLOSE_END = CNT_W'(CLOSE_BITS - 1);
  localparam logic [FRM_W-1:0] FRM_END   = FRM_W'(NUM_FRAMES - 1);

  phase_t            phase, phaseNxt;
  logic [CNT_W-1:0]  cnt, cntNxt;
  logic [FRM_W-1:0]  frameCnt, frameNxt;
  logic              modeCrc, modeNxt;
  logic              lastFrame, expTrail;
  logic [CNT_W-1:0]  trailEnd;
  logic [3:0]        crcIdx;
  logic [1:0]        constIdx;

  assign lastFrame = (frameCnt == FRM_END);
  assign trailEnd  = (modeCrc && lastFrame) ? LAST_END : TRAIL_END;
  assign crcIdx    = 4'(CRC_BITS - 1 - int'(cnt));
  assign constIdx  = 2'(TRAIL_BITS - 1 - int'(cnt));
  assign expTrail  = modeCrc ? crc[crcIdx] : TRAIL_CONST[constIdx];
  assign done      = (phase == S_DONE);
  assign errN      = (phase != S_FAULT);

  always_comb begin
    stb      = '0;
    phaseNxt = phase;
    cntNxt   = cnt;
    frameNxt = frameCnt;
    modeNxt  = modeCrc;
    if (!progN) begin
      stb.restart = 1'b1;
      phaseNxt    = S_HUNT;
      cntNxt      = '0;
      frameNxt    = '0;
    end else if (bitValid) begin
      case (phase)
        S_HUNT: begin
          stb.shiftWin = 1'b1;
          if (markerHit) begin
            stb.restart = 1'b1;
            modeNxt     = crcMode;
            phaseNxt    = S_LEN;
            cntNxt      = '0;
          end
        end
        S_LEN: begin
          stb.crcEn    = 1'b1;
          stb.shiftLen = 1'b1;
          if (cnt == LEN_END) begin
            phaseNxt = S_PAD;
            cntNxt   = '0;
          end else cntNxt = cnt + 1'b1;
        end
        S_PAD: begin
          stb.crcEn = 1'b1;
          if (!bitIn) phaseNxt = S_FAULT;
          else if (cnt == PAD_END) begin
            phaseNxt = S_MARK;
            cntNxt   = '0;
          end else cntNxt = cnt + 1'b1;
        end
        S_MARK: begin
          stb.crcEn = 1'b1;
          if (bitIn) phaseNxt = S_FAULT;
          else begin
            phaseNxt = S_DATA;
            cntNxt   = '0;
          end
        end
        S_DATA: begin
          stb.crcEn     = 1'b1;
          stb.shiftData = 1'b1;
          if (cnt == DATA_END) begin
            phaseNxt = S_TRAIL;
            cntNxt   = '0;
          end else cntNxt = cnt + 1'b1;
        end
        S_TRAIL: begin
          if (bitIn != expTrail) phaseNxt = S_FAULT;
          else if (cnt == trailEnd) begin
            stb.loadFrame = 1'b1;
            frameNxt      = frameCnt + 1'b1;
            phaseNxt      = lastFrame ? S_CLOSE : S_MARK;
            cntNxt        = '0;
          end else cntNxt = cnt + 1'b1;
        end
        S_CLOSE: begin
          stb.crcEn = 1'b1;
          if (bitIn != (cnt != '0)) phaseNxt = S_FAULT;
          else if (cnt == CLOSE_END) phaseNxt = S_DONE;
          else cntNxt = cnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= S_HUNT;
      cnt      <= '0;
      frameCnt <= '0;
      modeCrc  <= 1'b0;
    end else begin
      phase    <= phaseNxt;
      cnt      <= cntNxt;
      frameCnt <= frameNxt;
      modeCrc  <= modeNxt;
    end
  end

  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!errN && progN) |=> !errN); // R11
  AST_PROG_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    !progN |=> (phase == S_HUNT && errN && !done)); // R12
  AST_DONE_FROM_CLOSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> ($past(phase) == S_CLOSE && $past(bitValid))); // R10
  AST_MODE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (phase != S_HUNT && progN) |=> $stable(modeCrc)); // R9
endmodule

// File: rtl/cfg_stream_checker.sv
module cfg_stream_checker
  import cfg_stream_pkg::*;
#(
  parameter int FRAME_BITS = 8,
  parameter int NUM_FRAMES = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  progN,
  input  logic                  bitIn,
  input  logic                  bitValid,
  input  logic                  crcMode,
  output logic [23:0]           lenCount,
  output logic [FRAME_BITS-1:0] frameData,
  output logic                  frameValid,
  output logic                  done,
  output logic                  errN
);
  strobe_t             stb;
  logic                markerHit;
  logic [CRC_BITS-1:0] crc;

  cfg_stream_ctl #(.FRAME_BITS(FRAME_BITS), .NUM_FRAMES(NUM_FRAMES)) u_ctl (
    .clk(clk), .rstN(rstN), .progN(progN), .bitIn(bitIn), .bitValid(bitValid),
    .crcMode(crcMode), .markerHit(markerHit), .crc(crc), .stb(stb),
    .done(done), .errN(errN)
  );

  cfg_stream_dp #(.FRAME_BITS(FRAME_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .stb(stb), .markerHit(markerHit),
    .crc(crc), .lenCount(lenCount), .frameData(frameData), .frameValid(frameValid)
  );
endmodule

// File: tb/cfg_stream_checker_bench.sv
`timescale 1ns/1ps
module cfg_stream_checker_bench;
  localparam int FB = 8;
  localparam int NF = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0, progN = 1'b1, bitIn = 1'b0, bitValid = 1'b0, crcMode = 1'b0;
  logic [23:0] lenCount;
  logic [FB-1:0] frameData;
  logic frameValid, done, errN;

  int checks = 0, fails = 0, bitCount = 0, seedG = 0;
  logic [15:0] bcrc = '0;

  always #2.5 clk = ~clk;

  cfg_stream_checker #(.FRAME_BITS(FB), .NUM_FRAMES(NF)) u_cfg_stream_checker (
    .clk(clk), .rstN(rstN), .progN(progN), .bitIn(bitIn), .bitValid(bitValid),
    .crcMode(crcMode), .lenCount(lenCount), .frameData(frameData),
    .frameValid(frameValid), .done(done), .errN(errN)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crcStep(input logic [15:0] c, input logic b);
    logic [16:0] t;
    t = {c, 1'b0};
    if (c[15] ^ b) t = t ^ 17'h18005;
    return t[15:0];
  endfunction

  task automatic emit(input logic b, input bit upd);
    if (((bitCount + seedG) % 7) == 3) begin
      @(negedge clk); bitValid = 1'b0;
      @(posedge clk);
    end
    @(negedge clk); bitIn = b; bitValid = 1'b1;
    @(posedge clk); #1; bitValid = 1'b0;
    if (upd) bcrc = crcStep(bcrc, b);
    bitCount++;
  endtask

  task automatic progPulse();
    @(negedge clk); progN = 1'b0;
    @(posedge clk); #1; progN = 1'b1;
  endtask

  task automatic expectFault(input string req);
    chk(errN == 1'b0, req, errN, 0);
    chk(done == 1'b0, req, done, 0);
    for (int i = 0; i < 12; i++) begin
      emit((i % 4) == 2, 1'b0);
      chk(!errN && !frameValid && !done, "R11", {errN, frameValid, done}, 0);
    end
  endtask

  task automatic runStream(input bit useCrc, input int seed, input int fault);
    logic [23:0] len;
    logic [FB-1:0] d;
    logic b;
    int n;
    progPulse();
    chk(errN == 1'b1 && done == 1'b0, "R12", {errN, done}, 2);
    seedG = seed;
    crcMode = useCrc;
    for (int i = 0; i < 11; i++) emit((11'b10110011111 >> (10 - i)) & 1, 1'b0);
    chk(errN == 1'b1, "R1", errN, 1);
    emit(0, 0); emit(0, 0); emit(1, 0); emit(0, 0);
    bcrc = '0;
    crcMode = ~useCrc;  // R9: must be ignored from here on
    len = 24'h5A3C00 ^ 24'(seed * 499);
    for (int i = 23; i >= 0; i--) emit(len[i], 1'b1);
    chk(lenCount == len, "R2", lenCount, len);
    for (int i = 0; i < 4; i++) begin
      b = !(fault == 2 && i == 2);
      emit(b, 1'b1);
    end
    if (fault == 2) begin expectFault("R3"); return; end
    for (int f = 0; f < NF; f++) begin
      emit(fault == 3 && f == 1, 1'b1);
      if (fault == 3 && f == 1) begin expectFault("R4"); return; end
      chk(frameValid == 1'b0, "R5", frameValid, 0);
      d = FB'(seed * 37 + f * 91 + 5);
      for (int i = FB - 1; i >= 0; i--) emit(d[i], 1'b1);
      if (fault == 6 && f == 1) begin
        progPulse();
        chk(errN == 1'b1 && done == 1'b0 && frameValid == 1'b0, "R12", {errN, done, frameValid}, 4);
        return;
      end
      n = (useCrc && f == NF - 1) ? 11 : 4;
      for (int i = 0; i < n; i++) begin
        b = useCrc ? bcrc[15 - i] : ((4'b0110 >> (3 - i)) & 1);
        if (fault == 1 && f == 1 && i == 2) b = ~b;
        if (fault == 5 && f == NF - 1 && i == 10) b = ~b;
        emit(b, 1'b0);
      end
      if (fault == 1 && f == 1) begin expectFault(useCrc ? "R7" : "R6"); return; end
      if (fault == 5 && f == NF - 1) begin expectFault("R8"); return; end
      chk(frameValid == 1'b1, useCrc ? "R7 R9" : "R6 R9", frameValid, 1);
      chk(frameData == d, "R5", frameData, d);
      if (useCrc && f == NF - 1) chk(errN == 1'b1, "R8", errN, 1);
    end
    for (int i = 0; i < 8; i++) begin
      b = (i != 0);
      if (fault == 4 && i == 7) b = 1'b0;
      if (i == 7) chk(done == 1'b0, "R10", done, 0);
      emit(b, 1'b1);
    end
    if (fault == 4) begin expectFault("R10"); return; end
    chk(done == 1'b1 && errN == 1'b1, "R10", {done, errN}, 3);
    emit(0, 0); emit(1, 0);
    chk(done == 1'b1, "R10", done, 1);
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(errN == 1'b1 && done == 1'b0 && frameValid == 1'b0, "R11 reset", {errN, done, frameValid}, 4);
    chk(lenCount == '0, "R2 reset", lenCount, 0);
    @(negedge clk); rstN = 1'b1;
    for (int s = 0; s < 10; s++) runStream(1'b0, s, 0);
    for (int s = 0; s < 20; s++) runStream(1'b1, s * 3 + 1, 0);
    for (int m = 0; m < 2; m++) begin
      runStream(m[0], 5, 1);
      runStream(m[0], 6, 2);
      runStream(m[0], 7, 3);
      runStream(m[0], 8, 4);
      runStream(m[0], 9, 6);
      runStream(m[0], 10, 0);
    end
    runStream(1'b1, 11, 5);
    runStream(1'b1, 12, 0);
    finishRun();
  end
endmodule